// File: doc/BRIEF.md
# Bit-serial multi-input column adder

This block adds several two's complement streams that arrive one bit per clock, least significant bit first, all bit-aligned. Streams are combined in pairs by registered bit-serial adders arranged as a tree. Each tree level halves the number of streams, and the last level delivers a single serial sum stream. One clock of latency is added at every level.

A word is framed by a one-cycle start pulse that is high together with the word's least significant bit. The start pulse moves through the tree one level per clock, in step with the data. Every level therefore drops its carries on the first bit of its own word. Back-to-back words then need no idle cycle between them. When a level has an odd number of streams, the extra stream is held in a one-bit delay register so that it stays aligned with the adder outputs.

The delayed start pulse is an output, and downstream logic uses it to find the sum's first bit. The word length is set only by the upstream framing, and the RTL does not depend on it. The caller extends each input word with at least ceil(log2 N) copies of its sign bit, so the sum always fits in the shared word length.

Top module: `sca_column_adder`

## Requirements
- R1: A synchronous active-high reset clears `sum_out` and `init_out` to 0, whatever the inputs are during reset.
- R2: For words framed by `init_in`, the serial word on `sum_out` equals the two's complement sum of the N input words, modulo 2^W, where W is the framed word length. The sum is sent LSB first.
- R3: Bit k of a sum word appears on `sum_out` exactly L = ceil(log2 N) clocks after bit k of the input words was sampled. L is 3 for N = 8.
- R4: `init_out` equals `init_in` delayed by exactly L clocks, so it is high together with the LSB of every sum word.
- R5: A start pulse clears the carries at every level, so a carry left from the last bit of one word never enters the next word. This holds even when the words follow each other with no gap. As a result, the LSB of each sum word is the XOR of the input LSBs.
- R6: When N is not a power of two, each level passes its odd leftover stream through a one-bit delay register. The sum then stays exact and the latency stays L. With N = 5 the latency is 3.
- R7: If the inputs are D-bit values sign-extended by L guard bits, so that W = D + L, the result is exact even at the extremes. With D = 8 and N = 8, this includes all inputs at -128 (sum -1024) and all inputs at +127 (sum +1016).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | N_IN | One current bit from each input stream |
| init_in | input | 1 | High with the LSB of each input word |
| sum_out | output | 1 | Serial sum, LSB first |
| init_out | output | 1 | `init_in` delayed by the tree latency |

## Verification
If a carry register is stuck or fails to clear, the first sum word that depends on it comes out wrong. This shows within L + W clocks, and the LSB parity of the next word also breaks as soon as `init_out` rises. A fault in the start-pulse pipeline moves `init_out` away from its slot L clocks after `init_in`. It also makes the level behind the fault clear its carries on the wrong bit, which corrupts the sum word that is framed against the expected slot. A lost or misaligned leftover stream in the five-input instance shows up as wrong sums, because that stream then lands on the wrong bit weight.

// File: rtl/sca_pkg.sv
package sca_pkg;

    // State of one registered bit-serial adder
    typedef struct packed {
        logic sum;
        logic carry;
    } sca_add_state_t;

    // Number of tree levels for n input streams
    function automatic int unsigned sca_levels(input int unsigned n);
        return $clog2(n);
    endfunction

    // Streams present at the input of level lvl (level 0 = block inputs)
    function automatic int unsigned sca_count(input int unsigned n, input int unsigned lvl);
        int unsigned c;
        c = n;
        for (int unsigned i = 0; i < lvl; i++) c = (c + 1) / 2;
        return c;
    endfunction

    // Bit offset of level lvl's streams inside the flattened lane bus
    function automatic int unsigned sca_offset(input int unsigned n, input int unsigned lvl);
        int unsigned off;
        off = 0;
        for (int unsigned i = 0; i < lvl; i++) off += sca_count(n, i);
        return off;
    endfunction

endpackage

// File: rtl/sca_serial_add.sv
module sca_serial_add
    import sca_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic a,
    input  logic b,
    output logic sum_o
);

    sca_add_state_t st_q;
    sca_add_state_t st_d;
    logic           cin;

    // A start pulse replaces the stored carry with zero on the word's LSB
    always_comb begin
        cin        = clr ? 1'b0 : st_q.carry;
        st_d.sum   = a ^ b ^ cin;
        st_d.carry = (a & b) | (cin & (a ^ b));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sum_o = st_q.sum;

endmodule

// File: rtl/sca_bit_delay.sv
module sca_bit_delay (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

endmodule

// File: rtl/sca_level.sv
module sca_level #(
    parameter int unsigned IN_CNT = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      init_i,
    input  logic [IN_CNT-1:0]         str_i,
    output logic                      init_o,
    output logic [(IN_CNT+1)/2-1:0]   str_o
);

    localparam int unsigned OUT_CNT = (IN_CNT + 1) / 2;
    localparam int unsigned PAIRS   = IN_CNT / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        sca_serial_add u_add (
            .clk   (clk),
            .rst   (rst),
            .clr   (init_i),
            .a     (str_i[2*p]),
            .b     (str_i[2*p+1]),
            .sum_o (str_o[p])
        );
    end

    if ((IN_CNT % 2) != 0) begin : g_odd
        sca_bit_delay u_pass (
            .clk (clk),
            .rst (rst),
            .d   (str_i[IN_CNT-1]),
            .q   (str_o[OUT_CNT-1])
        );
    end

    // Start pulse advances one level per clock, matching the data
    always_ff @(posedge clk) begin
        if (rst) init_o <= 1'b0;
        else     init_o <= init_i;
    end

endmodule

// File: rtl/sca_column_adder.sv
module sca_column_adder
    import sca_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] data_in,
    input  logic            init_in,
    output logic            sum_out,
    output logic            init_out
);

    localparam int unsigned LEVELS = sca_levels(N_IN);
    localparam int unsigned TOTAL  = sca_offset(N_IN, LEVELS) + 1;

    // Every level's streams packed back to back; the last bit is the sum
    logic [TOTAL-1:0] lane;
    logic [LEVELS:0]  init_chain;

    assign lane[N_IN-1:0] = data_in;
    assign init_chain[0]  = init_in;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned CNT_I = sca_count(N_IN, l);
        localparam int unsigned CNT_O = sca_count(N_IN, l + 1);
        localparam int unsigned OFF_I = sca_offset(N_IN, l);
        localparam int unsigned OFF_O = sca_offset(N_IN, l + 1);

        sca_level #(.IN_CNT(CNT_I)) u_level (
            .clk    (clk),
            .rst    (rst),
            .init_i (init_chain[l]),
            .str_i  (lane[OFF_I +: CNT_I]),
            .init_o (init_chain[l+1]),
            .str_o  (lane[OFF_O +: CNT_O])
        );
    end

    assign sum_out  = lane[TOTAL-1];
    assign init_out = init_chain[LEVELS];

endmodule

// File: rtl/sca_column_adder_chk.sv
module sca_column_adder_chk #(
    parameter int unsigned N_IN = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] data_in,
    input logic            init_in,
    input logic            sum_out,
    input logic            init_out
);

    localparam int unsigned LEVELS = sca_pkg::sca_levels(N_IN);

    // Cycles since reset, saturating at the tree depth
    int unsigned since_rst;
    always_ff @(posedge clk) begin
        if (rst)                     since_rst <= 0;
        else if (since_rst < LEVELS) since_rst <= since_rst + 1;
    end

    // R1: outputs are cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!sum_out && !init_out));

    // R1: outputs never unknown out of reset
    a_r1_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({sum_out, init_out}));

    // R4: start pulse emerges exactly LEVELS clocks later
    a_r4_init_delay: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LEVELS) |-> (init_out == $past(init_in, LEVELS)));

    // R5: carries cleared on the LSB, so the sum LSB is the input parity
    a_r5_lsb_parity: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LEVELS && init_out) |-> (sum_out == ^$past(data_in, LEVELS)));

endmodule

bind sca_column_adder sca_column_adder_chk #(.N_IN(N_IN)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .init_in  (init_in),
    .sum_out  (sum_out),
    .init_out (init_out)
);

// File: tb/test_sca_column_adder.sv
module test_sca_column_adder;

    localparam int NT = 8;            // main instance inputs
    localparam int NO = 5;            // odd instance inputs
    localparam int LV = 3;            // ceil(log2) for both
    localparam int DW = 8;            // payload width
    localparam int W  = DW + LV;      // framed word length with guard bits
    localparam int QD = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] data_in = '0;
    logic          init_in = 1'b0;
    logic          sum8, init8, sum5, init5;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sca_column_adder #(.N_IN(NT)) i_sca_column_adder (
        .clk(clk), .rst(rst), .data_in(data_in), .init_in(init_in),
        .sum_out(sum8), .init_out(init8));

    sca_column_adder #(.N_IN(NO)) i_sca_column_adder_odd (
        .clk(clk), .rst(rst), .data_in(data_in[NO-1:0]), .init_in(init_in),
        .sum_out(sum5), .init_out(init5));

    // Expected word queues, one per instance
    logic [W-1:0] exp_q [2][QD];
    string        exp_tag [QD];
    int           wr = 0;
    int           rd [2] = '{0, 0};

    function automatic logic [W-1:0] ref_sum(input logic signed [DW-1:0] v [NT], input int cnt);
        int acc;
        acc = 0;
        for (int i = 0; i < cnt; i++) acc += int'(v[i]);
        return acc[W-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Start-pulse history sampled at the consuming edge (R3, R4 timing model)
    logic [LV-1:0] hist = '0;
    always @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[LV-2:0], init_in};
    end

    // Collector: words anchored LV clocks after the input start pulse
    logic [W-1:0] acc [2];
    int           pos [2] = '{0, 0};
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                logic ib, sb;
                ib = (k == 0) ? init8 : init5;
                sb = (k == 0) ? sum8  : sum5;
                if (ib || hist[LV-1])
                    check(ib == hist[LV-1], "R4", "init_out delay", int'(ib), int'(hist[LV-1]));
                if (hist[LV-1]) begin
                    acc[k] = '0;
                    acc[k][0] = sb;
                    pos[k] = 1;
                end else if (pos[k] > 0) begin
                    acc[k][pos[k]] = sb;
                    pos[k]++;
                end
                if (pos[k] == W) begin
                    pos[k] = 0;
                    // R2 R3 plus the tag of the stimulus phase
                    check(acc[k] == exp_q[k][rd[k] % QD],
                          exp_tag[rd[k] % QD], (k == 0) ? "R2 R3 sum word n8" : "R6 sum word n5",
                          int'(acc[k]), int'(exp_q[k][rd[k] % QD]));
                    rd[k]++;
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            data_in = '0;
            init_in = 1'b0;
        end
    endtask

    task automatic send_word(input logic signed [DW-1:0] v [NT], input string tag);
        logic [W-1:0] ext [NT];
        for (int i = 0; i < NT; i++) ext[i] = {{LV{v[i][DW-1]}}, v[i]};
        exp_q[0][wr % QD] = ref_sum(v, NT);
        exp_q[1][wr % QD] = ref_sum(v, NO);
        exp_tag[wr % QD]  = tag;
        wr++;
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            for (int i = 0; i < NT; i++) data_in[i] = ext[i][b];
            init_in = (b == 0);
        end
    endtask

    initial begin
        logic signed [DW-1:0] v [NT];
        int unsigned seed_tap;
        seed_tap = $urandom(32'd7741);

        // R1: reset with busy inputs
        data_in = '1;
        init_in = 1'b1;
        repeat (4) @(negedge clk);
        check(sum8 == 1'b0 && init8 == 1'b0, "R1", "reset outputs n8", int'({sum8, init8}), 0);
        check(sum5 == 1'b0 && init5 == 1'b0, "R1", "reset outputs n5", int'({sum5, init5}), 0);
        rst = 1'b0;
        data_in = '0;
        init_in = 1'b0;
        idle(3);

        // R7: extremes with exactly LV guard bits
        for (int i = 0; i < NT; i++) v[i] = -8'sd128;
        send_word(v, "R7 min");
        for (int i = 0; i < NT; i++) v[i] = 8'sd127;
        send_word(v, "R7 max");
        for (int i = 0; i < NT; i++) v[i] = (i % 2 == 0) ? 8'sd127 : -8'sd128;
        send_word(v, "R7 alternate");

        // R5: carry-heavy words back to back, then zeros
        for (int i = 0; i < NT; i++) v[i] = -8'sd1;
        send_word(v, "R5 all ones");
        for (int i = 0; i < NT; i++) v[i] = 8'sd0;
        send_word(v, "R5 zero after carries");
        for (int i = 0; i < NT; i++) v[i] = -8'sd128;
        send_word(v, "R5 min after zero");
        for (int i = 0; i < NT; i++) v[i] = 8'sd1;
        send_word(v, "R5 ones after min");
        idle(2);

        // R6: only the leftover lane of the odd instance is nonzero
        for (int i = 0; i < NT; i++) v[i] = 8'sd0;
        v[NO-1] = -8'sd77;
        send_word(v, "R6 leftover lane");

        // R2: random words, mostly back to back, some gaps
        for (int w = 0; w < 60; w++) begin
            for (int i = 0; i < NT; i++) v[i] = DW'($urandom);
            send_word(v, "R2 random");
            if (w % 9 == 4) idle(w % 4 + 1);
        end
        idle(W + LV + 4);

        check(rd[0] == wr, "R2", "words seen n8", rd[0], wr);
        check(rd[1] == wr, "R6", "words seen n5", rd[1], wr);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule